// File: doc/BRIEF.md
# Control Channel Word Capture

This block recovers fixed-length 78-bit signalling words from one of four control-channel bit streams. Each channel delivers an already-sampled data bit together with a one-cycle bit strobe. A periodic frame tick marks the nominal start of each word. Because a word may reach the block one to three bit times after the tick, a host-set offset discards a number of leading strobes before capture begins.

The host uses a small register port to choose the channel and the offset. It reads each completed word from a byte-wide window over a holding buffer. When a word completes, it moves from the assembly shift register into the holding buffer and raises a sticky ready flag. If the host has not consumed the previous word by then, an overrun flag records the loss and the newer word replaces the older one.

Register map:

- Address 0 is the configuration register. Bits [1:0] select the channel and bits [3:2] hold the offset.
- Address 1 is the status register. Bit 0 is ready and bit 1 is overrun.
- Addresses 2 to 11 are the word bytes.
- All other addresses read as zero.

Top module: `ccw_capture`

## Requirements
- R1: After reset, `word_ready` and `overrun` are 0, and address 0 reads 0x04 (channel 0, offset 1).
- R2: Only the active channel's strobes and bits affect capture. Strobes and bits on the other three channels have no effect on the captured word.
- R3: A write to the channel field takes effect at the next frame tick. A capture already in progress completes from the channel that was active when it started.
- R4: After a frame tick, the first N strobes of the active channel are discarded, where N is the offset field (1 to 3). An offset of 0 acts as 1. Channel and offset are taken from the configuration register as it stands in the tick cycle.
- R5: The next 78 strobes are captured MSB first, so the first captured bit is word bit 77. The word is exposed padded with two zero LSBs: address 2+k returns padded bits [79-8k:72-8k], and address 11 holds word bits 5..0 followed by 00. On the 78th strobe, `word_ready` is set at the same clock edge.
- R6: A read of address 11 clears `word_ready` and `overrun`. Reads of any other address leave both flags unchanged.
- R7: If a word completes while `word_ready` is set and address 11 is not being read in that cycle, `overrun` is set and the buffer holds the newer word.
- R8: A frame tick restarts alignment and discards any partial word. A strobe in the same cycle as the tick is ignored.
- R9: Once a word completes, further strobes are ignored until the next frame tick.
- R10: If a word completes in the same cycle that address 11 is read, the read returns the old byte, `word_ready` stays 1, `overrun` becomes 0, and the buffer holds the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ch_bit | input | 4 | Sampled data bit per channel |
| ch_stb | input | 4 | One-cycle bit strobe per channel |
| frame_tick | input | 1 | Word-frame tick pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on address 11) |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| word_ready | output | 1 | Sticky ready flag |
| overrun | output | 1 | Word-lost flag |

## Verification
The hardest case to reach is the 78th bit strobe landing in the same clock cycle as the host's read of the last buffer byte. In that cycle the clear and the set of the ready flag compete, and the read must still return the old word. The stimulus holds one word unread and then sends the next word, gating its final strobe by hand so that the same cycle also drives the read of address 11. A behavioural queue-based model runs alongside on every clock. It follows the same edge: a channel write in mid-capture, a tick that cuts a word short, and a strobe that arrives together with the tick.

// File: rtl/ccw_pkg.sv
package ccw_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_SKIP = 2'd1,
    FR_CAP  = 2'd2
  } fr_state_e;

  function automatic int unsigned bytes_for(input int unsigned nbits, input int unsigned bw);
    return (nbits + bw - 1) / bw;
  endfunction
endpackage

// File: rtl/ccw_chan_sel.sv
module ccw_chan_sel #(
  parameter int NUM_CH = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic [SEL_W-1:0]  sel_cfg,
  input  logic [NUM_CH-1:0] ch_bit,
  input  logic [NUM_CH-1:0] ch_stb,
  output logic [SEL_W-1:0]  act_ch,
  output logic              sel_bit,
  output logic              sel_stb
);
  logic [SEL_W-1:0]  act_q, act_d;
  logic [NUM_CH-1:0] hit;

  // active channel is latched only on the frame tick
  always_comb begin
    act_d = act_q;
    if (frame_tick) act_d = sel_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else if (frame_tick) act_q <= act_d;
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_lane
    assign hit[gi] = (act_q == SEL_W'(gi));
  end

  assign sel_stb = |(ch_stb & hit);
  assign sel_bit = |(ch_bit & hit);
  assign act_ch  = act_q;
endmodule

// File: rtl/ccw_framer.sv
module ccw_framer
  import ccw_pkg::*;
#(
  parameter int WORD_BITS = 78,
  parameter int OFS_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_tick,
  input  logic                 bit_in,
  input  logic                 bit_stb,
  input  logic [OFS_W-1:0]     ofs_cfg,
  output logic                 word_done,
  output logic [WORD_BITS-1:0] word_out
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);

  fr_state_e            state_q, state_d;
  logic [OFS_W-1:0]     skip_q, skip_d, ofs_eff;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [WORD_BITS-1:0] sh_q;
  logic                 sh_en;

  assign ofs_eff  = (ofs_cfg == '0) ? OFS_W'(1) : ofs_cfg;
  assign word_out = {sh_q[WORD_BITS-2:0], bit_in};

  always_comb begin
    state_d   = state_q;
    skip_d    = skip_q;
    cnt_d     = cnt_q;
    sh_en     = 1'b0;
    word_done = 1'b0;
    if (frame_tick) begin
      state_d = FR_SKIP;
      skip_d  = ofs_eff;
      cnt_d   = '0;
    end else if (bit_stb) begin
      case (state_q)
        FR_SKIP: begin
          if (skip_q == OFS_W'(1)) state_d = FR_CAP;
          else                     skip_d  = skip_q - OFS_W'(1);
        end
        FR_CAP: begin
          sh_en = 1'b1;
          if (cnt_q == CNT_W'(WORD_BITS - 1)) begin
            word_done = 1'b1;
            state_d   = FR_IDLE;
            cnt_d     = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      skip_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      skip_q  <= skip_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= word_out;
  end
endmodule

// File: rtl/ccw_holdbuf.sv
module ccw_holdbuf
  import ccw_pkg::*;
#(
  parameter int WORD_BITS = 78,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] word_in,
  input  logic                 rd_last,
  input  logic [IDX_W-1:0]     byte_idx,
  output logic [DATA_W-1:0]    byte_out,
  output logic                 ready,
  output logic                 overrun
);
  localparam int NBYTES   = int'(bytes_for(WORD_BITS, DATA_W));
  localparam int BUF_BITS = NBYTES * DATA_W;
  localparam int PAD      = BUF_BITS - WORD_BITS;

  logic [BUF_BITS-1:0] hold_q, hold_d;
  logic                rdy_q, rdy_d, ovr_q, ovr_d;
  logic [DATA_W-1:0]   bytes [NBYTES];

  if (PAD > 0) begin : g_pad
    assign hold_d = {word_in, {PAD{1'b0}}};
  end else begin : g_nopad
    assign hold_d = word_in;
  end

  for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
    assign bytes[gi] = hold_q[BUF_BITS-1-gi*DATA_W -: DATA_W];
  end

  always_comb begin
    rdy_d = rdy_q;
    if (load)         rdy_d = 1'b1;
    else if (rd_last) rdy_d = 1'b0;
    ovr_d = rd_last ? 1'b0 : (ovr_q | (load & rdy_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= hold_d;
  end

  assign byte_out = (32'(byte_idx) < NBYTES) ? bytes[byte_idx] : '0;
  assign ready    = rdy_q;
  assign overrun  = ovr_q;
endmodule

// File: rtl/ccw_capture.sv
module ccw_capture
  import ccw_pkg::*;
#(
  parameter int WORD_BITS = 78,
  parameter int NUM_CH    = 4,
  parameter int SEL_W     = 2,
  parameter int OFS_W     = 2,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_bit,
  input  logic [NUM_CH-1:0] ch_stb,
  input  logic              frame_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              word_ready,
  output logic              overrun
);
  localparam int NBYTES    = int'(bytes_for(WORD_BITS, DATA_W));
  localparam int IDX_W     = $clog2(NBYTES);
  localparam int ADDR_CFG  = 0;
  localparam int ADDR_STAT = 1;
  localparam int ADDR_BUF0 = 2;
  localparam int ADDR_BUFL = ADDR_BUF0 + NBYTES - 1;

  logic [1:0]           rs_q;
  logic                 rst_sync_n;
  logic [SEL_W-1:0]     sel_q, sel_d, act_ch;
  logic [OFS_W-1:0]     ofs_q, ofs_d;
  logic                 cfg_en, sel_bit, sel_stb, word_done, rd_last, in_buf;
  logic [WORD_BITS-1:0] word_bus;
  logic [IDX_W-1:0]     byte_idx;
  logic [ADDR_W-1:0]    addr_off;
  logic [DATA_W-1:0]    buf_byte;

  // reset: asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  // configuration register
  assign cfg_en = reg_wr && (reg_addr == ADDR_W'(ADDR_CFG));
  always_comb begin
    sel_d = reg_wdata[SEL_W-1:0];
    ofs_d = reg_wdata[SEL_W+OFS_W-1:SEL_W];
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sel_q <= '0;
      ofs_q <= OFS_W'(1);
    end else if (cfg_en) begin
      sel_q <= sel_d;
      ofs_q <= ofs_d;
    end
  end

  ccw_chan_sel #(.NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_sync_n), .frame_tick(frame_tick), .sel_cfg(sel_q),
    .ch_bit(ch_bit), .ch_stb(ch_stb), .act_ch(act_ch),
    .sel_bit(sel_bit), .sel_stb(sel_stb)
  );

  ccw_framer #(.WORD_BITS(WORD_BITS), .OFS_W(OFS_W)) u_frm (
    .clk(clk), .rst_n(rst_sync_n), .frame_tick(frame_tick), .bit_in(sel_bit),
    .bit_stb(sel_stb), .ofs_cfg(ofs_q), .word_done(word_done), .word_out(word_bus)
  );

  assign addr_off = reg_addr - ADDR_W'(ADDR_BUF0);
  assign byte_idx = addr_off[IDX_W-1:0];
  assign in_buf   = (reg_addr >= ADDR_W'(ADDR_BUF0)) && (reg_addr <= ADDR_W'(ADDR_BUFL));
  assign rd_last  = reg_rd && (reg_addr == ADDR_W'(ADDR_BUFL));

  ccw_holdbuf #(.WORD_BITS(WORD_BITS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_sync_n), .load(word_done), .word_in(word_bus),
    .rd_last(rd_last), .byte_idx(byte_idx), .byte_out(buf_byte),
    .ready(word_ready), .overrun(overrun)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(ADDR_CFG))       reg_rdata = DATA_W'({ofs_q, sel_q});
    else if (reg_addr == ADDR_W'(ADDR_STAT)) reg_rdata = DATA_W'({overrun, word_ready});
    else if (in_buf)                         reg_rdata = buf_byte;
  end
endmodule

// File: rtl/ccw_capture_chk.sv
module ccw_capture_chk #(
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 4,
  parameter int LAST_A = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              word_done,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [SEL_W-1:0]  act_ch,
  input logic              word_ready,
  input logic              overrun
);
  logic rd_l;
  assign rd_l = reg_rd && (reg_addr == ADDR_W'(LAST_A));

  assert_ready_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> word_ready);
  assert_clear_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_l && !word_done) |=> (!word_ready && !overrun));
  assert_flags_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_l && !word_done) |=> ($stable(word_ready) && $stable(overrun)));
  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && word_ready && !rd_l) |=> overrun);
  assert_overrun_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(word_ready));
  assert_chan_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(act_ch));
  assert_no_back_to_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);
  assert_coincide_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && rd_l) |=> (word_ready && !overrun));
endmodule

bind ccw_capture ccw_capture_chk #(.SEL_W(SEL_W), .ADDR_W(ADDR_W), .LAST_A(ADDR_BUFL)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .frame_tick(frame_tick), .word_done(word_done),
  .reg_rd(reg_rd), .reg_addr(reg_addr), .act_ch(act_ch),
  .word_ready(word_ready), .overrun(overrun)
);

// File: tb/tb_ccw_capture.sv
`timescale 1ns/1ps
module tb_ccw_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ch_bit = '0, ch_stb = '0;
  logic       frame_tick = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       word_ready, overrun;

  int  n_chk = 0, n_fail = 0;
  bit  noise = 1'b0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  ccw_capture dut (
    .clk(clk), .rst_n(rst_n), .ch_bit(ch_bit), .ch_stb(ch_stb), .frame_tick(frame_tick),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .word_ready(word_ready), .overrun(overrun)
  );

  // ---------------- behavioural reference model ----------------
  int          m_sel, m_ofs, m_act, m_skip, m_st;  // m_st: 0 idle, 1 skip, 2 capture
  bit          m_q[$];
  logic [79:0] m_hold;
  bit          m_rdy, m_ovr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel = 0; m_ofs = 1; m_act = 0; m_skip = 0; m_st = 0;
      m_q.delete(); m_hold = '0; m_rdy = 0; m_ovr = 0;
    end else begin
      bit rdl, dn;
      rdl = reg_rd && reg_addr == 4'd11;
      dn = 0;
      if (frame_tick) begin
        m_act = m_sel; m_skip = (m_ofs == 0) ? 1 : m_ofs; m_st = 1; m_q.delete();
      end else if (m_st != 0 && ch_stb[m_act]) begin
        if (m_st == 1) begin
          m_skip--;
          if (m_skip == 0) m_st = 2;
        end else begin
          m_q.push_back(ch_bit[m_act]);
          if (m_q.size() == 78) begin dn = 1; m_st = 0; end
        end
      end
      if (dn) begin
        for (int i = 0; i < 78; i++) m_hold[79-i] = m_q[i];
        m_hold[1:0] = 2'b00;
        m_q.delete();
      end
      if (rdl) m_ovr = 0;
      else if (dn && m_rdy) m_ovr = 1;
      if (dn) m_rdy = 1;
      else if (rdl) m_rdy = 0;
      if (reg_wr && reg_addr == 4'd0) begin
        m_sel = int'(reg_wdata[1:0]); m_ofs = int'(reg_wdata[3:2]);
      end
    end
  end

  function automatic logic [7:0] m_rdata(input logic [3:0] a);
    if (a == 0) return {4'b0, 2'(m_ofs), 2'(m_sel)};
    if (a == 1) return {6'b0, m_ovr, m_rdy};
    if (a >= 2 && a <= 11) return m_hold[79-8*(int'(a)-2) -: 8];
    return 8'h00;
  endfunction

  // per-cycle comparison, late in the cycle
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk); #3;
      n_chk++;
      if (word_ready !== m_rdy || overrun !== m_ovr || reg_rdata !== m_rdata(reg_addr)) begin
        n_fail++;
        $display("FAIL MODEL R1..: actual rdy=%b ovr=%b rdata=%h expected rdy=%b ovr=%b rdata=%h",
                 word_ready, overrun, reg_rdata, m_rdy, m_ovr, m_rdata(reg_addr));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [77:0] mkword(input int s);
    logic [77:0] w;
    for (int i = 0; i < 78; i++) w[i] = ((i * i * 3 + s * 5 + i * s) % 5) < 2;
    return w;
  endfunction

  task automatic tick();
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic strobe(input int ch, input bit b);
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      if (c == ch) begin ch_stb[c] = 1'b1; ch_bit[c] = b; end
      else if (noise) begin ch_stb[c] = 1'b1; ch_bit[c] = ~b; end
    end
    @(negedge clk); ch_stb = '0;
  endtask

  task automatic send(input int ch, input logic [77:0] w, input int nskip, input int hi, input int lo);
    for (int k = 0; k < nskip; k++) strobe(ch, 1'b1);
    for (int k = hi; k >= lo; k--) strobe(ch, w[k]);
  endtask

  task automatic cfg(input int sel, input int ofs);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 8'(ofs * 4 + sel);
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #3 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic check_word(input string tag, input logic [77:0] w);
    logic [79:0] p;
    logic [7:0]  d;
    p = {w, 2'b00};
    for (int j = 0; j < 10; j++) begin
      if (j == 9) check({tag, " R6 ready before last"}, 80'(word_ready), 80'(1));
      rd(4'(2 + j), d);
      check(tag, 80'(d), 80'(p[79-8*j -: 8]));
    end
    @(negedge clk); #3;
    check("R6 ready cleared", 80'(word_ready), 80'(0));
    check("R6 overrun cleared", 80'(overrun), 80'(0));
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [77:0] wa, wb;
    logic [7:0]  d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #3;
    check("R1 ready", 80'(word_ready), 80'(0));
    check("R1 overrun", 80'(overrun), 80'(0));
    rd(4'd0, d); check("R1 cfg", 80'(d), 80'(8'h04));

    // R2 / R5: channel 0, offset 1, with noise on other channels
    noise = 1; wa = mkword(1);
    tick(); send(0, wa, 1, 77, 0);
    @(negedge clk); #3; check("R5 ready set", 80'(word_ready), 80'(1));
    check_word("R2 R5 word", wa);
    noise = 0;

    // R4: offset 3 on channel 2
    cfg(2, 3); wa = mkword(2);
    tick(); send(2, wa, 3, 77, 0);
    check_word("R4 offset3", wa);
    // R4: offset 0 acts as 1
    cfg(1, 0); wa = mkword(3);
    tick(); send(1, wa, 1, 77, 0);
    check_word("R4 offset0", wa);

    // R3: select change mid-capture
    wa = mkword(4);
    tick(); send(1, wa, 1, 77, 40);
    cfg(3, 1);
    strobe(3, 1'b1); strobe(3, 1'b0);
    send(1, wa, 0, 39, 0);
    check_word("R3 old channel", wa);

    // R8: tick during capture, strobe coinciding with tick ignored
    wa = mkword(5); wb = mkword(6);
    tick(); send(3, wa, 1, 77, 50);
    @(negedge clk); frame_tick = 1'b1; ch_stb[3] = 1'b1; ch_bit[3] = 1'b0;
    @(negedge clk); frame_tick = 1'b0; ch_stb = '0;
    send(3, wb, 1, 77, 0);
    check_word("R8 restart", wb);

    // R9 then R7: extra strobes ignored, then overrun
    wa = mkword(7); wb = mkword(8);
    tick(); send(3, wa, 1, 77, 0);
    for (int k = 0; k < 90; k++) strobe(3, 1'b1);
    @(negedge clk); #3;
    check("R9 no overrun", 80'(overrun), 80'(0));
    rd(4'd2, d); check("R9 buffer kept", 80'(d), 80'(wa[77:70]));
    tick(); send(3, wb, 1, 77, 0);
    @(negedge clk); #3;
    check("R7 overrun", 80'(overrun), 80'(1));
    rd(4'd1, d); check("R7 status", 80'(d), 80'(8'h03));
    check_word("R7 newer word", wb);

    // R10: completion coinciding with last-byte read
    wa = mkword(9); wb = mkword(10);
    tick(); send(3, wa, 1, 77, 0);
    tick(); send(3, wb, 1, 77, 1);
    @(negedge clk);
    ch_stb[3] = 1'b1; ch_bit[3] = wb[0]; reg_rd = 1'b1; reg_addr = 4'd11;
    #3 d = reg_rdata;
    check("R10 old byte", 80'(d), 80'({wa[5:0], 2'b00}));
    @(negedge clk); ch_stb = '0; reg_rd = 1'b0; #3;
    check("R10 ready", 80'(word_ready), 80'(1));
    check("R10 overrun", 80'(overrun), 80'(0));
    check_word("R10 new word", wb);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule